// File: doc/BRIEF.md
# Wired-to-Message Interrupt Controller

This block turns a bank of wired interrupt lines into vectored interrupt messages. Each line is synchronised and then judged against its own trigger setting: rising edge, falling edge, active-high level or active-low level. Edge-mode lines keep a sticky pending latch. A line that is pending, unmasked, enabled and not already in service competes for a single message output. The lowest line index wins. The message carries the winning line's index together with its programmed 8-bit vector byte and 8-bit route byte.

Software configures the block through a simple 32-bit register port. Writes take effect on the clock edge and reads return data in the same cycle. Per-line settings live in bitmap registers of two words each. The vector and route tables are byte-addressed, one byte per line, and any byte can be written on its own using the lane strobes. Once a message has been accepted, its line stays in service until software writes a one to that line's clear bit. This keeps a level line that is still held from flooding the output.

The message output is a valid/ready stream. When a payload has been raised, valid stays high and the index, vector and route stay frozen until a cycle with ready high accepts them. A new payload is chosen only while valid is low. A line that becomes eligible while the output is stalled therefore waits; it is not lost.

Top module: `irqm_ctrl`

## Requirements
- R1: After reset, both mask words read 0xFFFFFFFF. The enable, edge, polarity and both auto-bounce words read 0, every route and vector byte reads 0, and msg_valid is low.
- R2: Bitmap words sit at these byte addresses: mask 0x020/0x024, enable 0x040/0x044, edge 0x060/0x064, clear 0x080/0x084, auto-bounce A 0x0C0/0x0C4, auto-bounce B 0x0E0/0x0E4, polarity 0x3E0/0x3E4. Line n is bit n%32 of the word at base+4*(n/32). Every word except clear reads back what was written; clear reads 0.
- R3: Line n's route byte is at byte address 0x100+n and its vector byte at 0x200+n. Both are reached through the word at the address rounded down to a multiple of 4, in byte lane n%4 (bits 8*(n%4)+7 down to 8*(n%4)). A write changes only the lanes whose wstrb bit is 1.
- R4: Trigger setting per line is {edge,pol}: 10 = rising edge, 11 = falling edge, 00 = high level, 01 = low level. A line held at its inactive level issues nothing.
- R5: Inputs pass a two-flop synchroniser. A level line is pending only while its synchronised input is at the active level. A level pulse that ends while the line is masked leaves nothing behind.
- R6: An edge line sets a sticky pending latch on its selected transition, whether or not it is masked. Writing 1 to a clear bit discards that line's latch and in-service state. Writing 0 changes nothing.
- R7: A line issues only when its mask bit is 0 and its enable bit is 1. The auto-bounce words have no effect on message generation.
- R8: A message carries the line index on msg_line and that line's vector and route bytes as they were when the message was raised.
- R9: When several lines are eligible, the lowest index is issued first.
- R10: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_line, msg_vector and msg_route hold their values.
- R11: A line whose message was accepted does not issue again until its clear bit is written. If that clear write falls in the same cycle as the acceptance, the clear wins and a line that is still pending issues again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Wired interrupt lines, asynchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Read data, same cycle as reg_rd_en |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_line | output | 6 | Index of the issuing line |
| msg_vector | output | 8 | Vector byte of the issuing line |
| msg_route | output | 8 | Route byte of the issuing line |

## Verification
The critical coincidence is a software clear write to a line landing in the same cycle in which the consumer accepts that line's message. The two paths pull the in-service bit in opposite directions. The bench stalls a held level line's message, then raises msg_ready and writes the line's clear bit together on one edge. It judges the outcome by whether the same line is issued again within a few cycles, which R11 requires. A further check then confirms that a normal acceptance without a clear keeps the line quiet.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  localparam int ADDR_W = 12;

  // bitmap register indices
  localparam int R_MASK = 0;
  localparam int R_EN   = 1;
  localparam int R_EDGE = 2;
  localparam int R_POL  = 3;
  localparam int R_ABA  = 4;
  localparam int R_ABB  = 5;
  localparam int NUM_CFG = 6;

  localparam int OFF_CLR   = 'h080;
  localparam int OFF_ROUTE = 'h100;
  localparam int OFF_VEC   = 'h200;

  function automatic int cfg_offset(input int r);
    case (r)
      R_MASK:  return 'h020;
      R_EN:    return 'h040;
      R_EDGE:  return 'h060;
      R_POL:   return 'h3E0;
      R_ABA:   return 'h0C0;
      default: return 'h0E0;
    endcase
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  strb);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = strb[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/irqm_regs.sv
module irqm_regs
  import irqm_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  input  logic [3:0]             wstrb,
  output logic [31:0]            rdata,
  output logic [NUM_LINES-1:0]   mask_q,
  output logic [NUM_LINES-1:0]   en_q,
  output logic [NUM_LINES-1:0]   edge_q,
  output logic [NUM_LINES-1:0]   pol_q,
  output logic [NUM_LINES-1:0]   clr_pulse,
  output logic [8*NUM_LINES-1:0] route_flat,
  output logic [8*NUM_LINES-1:0] vec_flat
);

  localparam int NUM_WORDS = NUM_LINES / 32;
  localparam int NUM_PARTS = NUM_CFG * NUM_WORDS + 2 * NUM_LINES;

  logic [32*NUM_PARTS-1:0] rd_parts;

  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(cfg_offset(r) + 4 * w);
      logic [31:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= (r == R_MASK) ? '1 : '0;
        else if (wr_en && addr == WADDR)
          q <= lane_merge(q, wdata, wstrb);
      end
      assign rd_parts[32*(r*NUM_WORDS+w) +: 32] = (rd_en && addr == WADDR) ? q : '0;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_out
    assign mask_q[32*w +: 32] = g_cfg[R_MASK].g_word[w].q;
    assign en_q[32*w +: 32]   = g_cfg[R_EN].g_word[w].q;
    assign edge_q[32*w +: 32] = g_cfg[R_EDGE].g_word[w].q;
    assign pol_q[32*w +: 32]  = g_cfg[R_POL].g_word[w].q;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int LANE = n % 4;
    localparam logic [ADDR_W-1:0] CADDR = ADDR_W'(OFF_CLR + 4 * (n / 32));
    localparam logic [ADDR_W-1:0] RADDR = ADDR_W'(OFF_ROUTE + 4 * (n / 4));
    localparam logic [ADDR_W-1:0] VADDR = ADDR_W'(OFF_VEC + 4 * (n / 4));
    logic [7:0] rt;
    logic [7:0] vc;

    assign clr_pulse[n] = wr_en && addr == CADDR && wstrb[(n % 32) / 8] && wdata[n % 32];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rt <= '0;
        vc <= '0;
      end else if (wr_en && wstrb[LANE]) begin
        if (addr == RADDR) rt <= wdata[8*LANE +: 8];
        if (addr == VADDR) vc <= wdata[8*LANE +: 8];
      end
    end

    assign route_flat[8*n +: 8] = rt;
    assign vec_flat[8*n +: 8]   = vc;

    assign rd_parts[32*(NUM_CFG*NUM_WORDS+2*n) +: 32] =
      (rd_en && addr == RADDR) ? (32'(rt) << (8 * LANE)) : '0;
    assign rd_parts[32*(NUM_CFG*NUM_WORDS+2*n+1) +: 32] =
      (rd_en && addr == VADDR) ? (32'(vc) << (8 * LANE)) : '0;
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PARTS; p++)
      rdata = rdata | rd_parts[32*p +: 32];
  end

endmodule

// File: rtl/irqm_detect.sv
module irqm_detect #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] edge_q,
  input  logic [NUM_LINES-1:0] pol_q,
  input  logic [NUM_LINES-1:0] clr_pulse,
  input  logic [NUM_LINES-1:0] accept,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] insvc_q
);

  logic [NUM_LINES-1:0] sync1_q, sync2_q, prev_q, latch_q;
  logic [NUM_LINES-1:0] rise, fall, edge_ev;

  assign rise    = sync2_q & ~prev_q;
  assign fall    = prev_q & ~sync2_q;
  assign edge_ev = edge_q & ((rise & ~pol_q) | (fall & pol_q));
  assign pending = (edge_q & latch_q) | (~edge_q & (sync2_q ^ pol_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
      insvc_q <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      // a fresh transition outranks a clear landing on the same edge
      latch_q <= edge_ev | (latch_q & ~clr_pulse);
      // a clear outranks an acceptance on the same edge
      insvc_q <= (insvc_q | accept) & ~clr_pulse;
    end
  end

endmodule

// File: rtl/irqm_prio.sv
module irqm_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end

  assign any = |req;

endmodule

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
  import irqm_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_in,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  input  logic [3:0]            reg_wstrb,
  output logic [31:0]           reg_rdata,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [LINE_W-1:0]     msg_line,
  output logic [7:0]            msg_vector,
  output logic [7:0]            msg_route
);

  logic [NUM_LINES-1:0]   mask_w, en_w, edge_w, pol_w, clr_w;
  logic [8*NUM_LINES-1:0] route_flat, vec_flat;
  logic [NUM_LINES-1:0]   pending, insvc_q, eligible, accept;
  logic                   win_any;
  logic [LINE_W-1:0]      win_idx;
  logic                   fire;

  logic                   valid_q;
  logic [LINE_W-1:0]      line_q;
  logic [7:0]             vec_q, route_q;

  irqm_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .wstrb(reg_wstrb), .rdata(reg_rdata),
    .mask_q(mask_w), .en_q(en_w), .edge_q(edge_w), .pol_q(pol_w),
    .clr_pulse(clr_w), .route_flat(route_flat), .vec_flat(vec_flat)
  );

  irqm_detect #(.NUM_LINES(NUM_LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .edge_q(edge_w), .pol_q(pol_w), .clr_pulse(clr_w),
    .accept(accept), .pending(pending), .insvc_q(insvc_q)
  );

  assign eligible = pending & ~mask_w & en_w & ~insvc_q;

  irqm_prio #(.N(NUM_LINES), .IW(LINE_W)) u_prio (
    .req(eligible), .any(win_any), .idx(win_idx)
  );

  assign fire   = valid_q && msg_ready;
  assign accept = fire ? (NUM_LINES'(1) << line_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      vec_q   <= '0;
      route_q <= '0;
    end else if (!valid_q) begin
      if (win_any) begin
        valid_q <= 1'b1;
        line_q  <= win_idx;
        vec_q   <= vec_flat[8*win_idx +: 8];
        route_q <= route_flat[8*win_idx +: 8];
      end
    end else if (msg_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid  = valid_q;
  assign msg_line   = line_q;
  assign msg_vector = vec_q;
  assign msg_route  = route_q;

endmodule

// File: rtl/irqm_ctrl_chk.sv
module irqm_ctrl_chk #(
  parameter int NUM_LINES = 64,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [LINE_W-1:0]    msg_line,
  input logic [7:0]           msg_vector,
  input logic [7:0]           msg_route,
  input logic [NUM_LINES-1:0] mask_w,
  input logic [NUM_LINES-1:0] en_w,
  input logic [NUM_LINES-1:0] eligible,
  input logic [NUM_LINES-1:0] insvc_q,
  input logic [NUM_LINES-1:0] clr_w
);

  function automatic logic [NUM_LINES-1:0] below(input logic [LINE_W-1:0] k);
    logic [NUM_LINES-1:0] m;
    for (int i = 0; i < NUM_LINES; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_line)
                                && $stable(msg_vector) && $stable(msg_route));

  a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (($past(eligible) & below(msg_line)) == '0));

  a_r7_open_line_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> ((($past(en_w) & ~$past(mask_w)) >> msg_line) & 1) == 1);

  a_r11_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && !clr_w[msg_line] |=> insvc_q[$past(msg_line)]);

  a_r6_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_w) |=> ((insvc_q & $past(clr_w)) == '0));

endmodule

bind irqm_ctrl irqm_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_line(msg_line), .msg_vector(msg_vector), .msg_route(msg_route),
  .mask_w(mask_w), .en_w(en_w), .eligible(eligible), .insvc_q(insvc_q),
  .clr_w(clr_w)
);

// File: tb/irqm_ctrl_bench.sv
module irqm_ctrl_bench;

  localparam logic [11:0] A_MASK = 12'h020, A_EN = 12'h040, A_EDGE = 12'h060,
                          A_CLR = 12'h080, A_ABA = 12'h0C0, A_ABB = 12'h0E0,
                          A_POL = 12'h3E0, A_RT = 12'h100, A_VC = 12'h200;

  logic        clk = 0, rst_n = 0;
  logic [63:0] irq_in = '0;
  logic        reg_wr_en = 0, reg_rd_en = 0, msg_ready = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_wstrb = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid;
  logic [5:0]  msg_line;
  logic [7:0]  msg_vector, msg_route;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irqm_ctrl u_irqm_ctrl (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
    @(negedge clk);
    reg_wr_en = 0; reg_wstrb = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd_en = 0;
  endtask

  task automatic set_bit(input logic [11:0] base, input int n, input bit v);
    logic [31:0] d;
    rd(base + 12'(4 * (n / 32)), d);
    d[n % 32] = v;
    wr(base + 12'(4 * (n / 32)), d, 4'hF);
  endtask

  task automatic clear_line(input int n);
    wr(A_CLR + 12'(4 * (n / 32)), 32'd1 << (n % 32), 4'hF);
  endtask

  task automatic put_byte(input logic [11:0] base, input int n, input logic [7:0] b);
    wr(base + 12'(n & ~3), 32'(b) << (8 * (n % 4)), 4'b0001 << (n % 4));
  endtask

  task automatic wait_msg(input int cyc, output bit got);
    got = 0;
    for (int i = 0; i < cyc && !got; i++) begin
      @(negedge clk);
      if (msg_valid) got = 1;
    end
  endtask

  task automatic take();
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  // idle and active input levels for a {edge,pol} setting
  function automatic bit idle_lvl(input bit pol);
    return pol;
  endfunction

  task automatic cfg_line(input int n, input bit e, input bit p, input logic [7:0] v, input logic [7:0] r);
    set_bit(A_EDGE, n, e);
    set_bit(A_POL, n, p);
    put_byte(A_VC, n, v);
    put_byte(A_RT, n, r);
    set_bit(A_EN, n, 1);
  endtask

  task automatic retire_line(input int n);
    set_bit(A_MASK, n, 1);
    set_bit(A_EN, n, 0);
    irq_in[n] = 0;
    repeat (5) @(negedge clk);
    set_bit(A_EDGE, n, 0);
    set_bit(A_POL, n, 0);
    clear_line(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit got;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(msg_valid == 0, "R1 valid", 32'(msg_valid), 0);
    rd(A_MASK, d);     chk(d == '1, "R1 mask0", d, '1);
    rd(A_MASK + 4, d); chk(d == '1, "R1 mask1", d, '1);
    rd(A_EN + 4, d);   chk(d == 0, "R1 en", d, 0);
    rd(A_POL, d);      chk(d == 0, "R1 pol", d, 0);
    rd(A_ABB + 4, d);  chk(d == 0, "R1 autobounce", d, 0);
    rd(A_VC + 12'h3C, d); chk(d == 0, "R1 vector", d, 0);

    // R2 readback and clear reads zero
    wr(A_EDGE + 4, 32'hA5A5_0001, 4'hF);
    rd(A_EDGE + 4, d); chk(d == 32'hA5A5_0001, "R2 edge readback", d, 32'hA5A5_0001);
    wr(A_EDGE + 4, 32'h0, 4'hF);
    rd(A_CLR, d); chk(d == 0, "R2 clear reads 0", d, 0);

    // R3 byte lane strobes
    wr(A_RT + 4, 32'hAABB_77CC, 4'b0010);
    rd(A_RT + 4, d); chk(d == 32'h0000_7700, "R3 route lane", d, 32'h0000_7700);

    // random single-line trials: R4 R8 R11
    for (int t = 0; t < 24; t++) begin
      int n;
      bit e, p;
      logic [7:0] v, r;
      n = int'($urandom_range(63, 0));
      e = 1'($urandom); p = 1'($urandom);
      v = 8'($urandom); r = 8'($urandom);
      cfg_line(n, e, p, v, r);
      irq_in[n] = idle_lvl(p);
      repeat (5) @(negedge clk);
      clear_line(n);
      set_bit(A_MASK, n, 0);
      wait_msg(6, got);
      chk(!got, "R4 idle line quiet", 32'(got), 0);
      irq_in[n] = ~idle_lvl(p);
      wait_msg(12, got);
      chk(got && msg_line == 6'(n), "R4 trigger issue", 32'(msg_line), 32'(n));
      chk(msg_vector == v && msg_route == r, "R8 payload",
          {16'h0, msg_vector, msg_route}, {16'h0, v, r});
      take();
      wait_msg(10, got);
      chk(!got, "R11 no reissue", 32'(got), 0);
      retire_line(n);
    end

    // R9 priority, R10 back-pressure, R11 clear vs accept collision
    put_byte(A_VC, 5, 8'h11);
    cfg_line(5, 0, 0, 8'h11, 8'h77);
    cfg_line(40, 0, 0, 8'h28, 8'h99);
    set_bit(A_MASK, 5, 0);
    set_bit(A_MASK, 40, 0);
    irq_in[5] = 1; irq_in[40] = 1;
    wait_msg(12, got);
    chk(got && msg_line == 5, "R9 lowest first", 32'(msg_line), 5);
    chk(msg_route == 8'h77, "R3 route via message", 32'(msg_route), 32'h77);
    take();
    wait_msg(8, got);
    chk(got && msg_line == 40 && msg_vector == 8'h28, "R9 next line",
        {msg_vector, 18'h0, msg_line}, {8'h28, 18'h0, 6'd40});
    begin
      bit steady = 1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (!msg_valid || msg_line != 40 || msg_route != 8'h99) steady = 0;
      end
      chk(steady, "R10 stalled payload held", 32'(steady), 1);
    end
    @(negedge clk);
    msg_ready = 1;
    reg_wr_en = 1; reg_addr = A_CLR + 4; reg_wdata = 32'd1 << 8; reg_wstrb = 4'hF;
    @(negedge clk);
    msg_ready = 0; reg_wr_en = 0; reg_wstrb = '0;
    wait_msg(8, got);
    chk(got && msg_line == 40, "R11 clear beats accept", 32'(msg_line), 40);
    take();
    wait_msg(10, got);
    chk(!got, "R11 held lines stay quiet", 32'(got), 0);
    retire_line(5);
    retire_line(40);

    // R7 mask and enable, auto-bounce inert
    cfg_line(63, 0, 0, 8'h3F, 8'h01);
    irq_in[63] = 1;
    wait_msg(10, got);
    chk(!got, "R7 masked quiet", 32'(got), 0);
    set_bit(A_MASK, 63, 0);
    wait_msg(10, got);
    chk(got && msg_line == 63, "R7 unmask issues", 32'(msg_line), 63);
    take();
    retire_line(63);
    wr(A_ABA, '1, 4'hF); wr(A_ABB, '1, 4'hF);
    rd(A_ABA, d); chk(d == '1, "R2 auto-bounce stored", d, '1);
    cfg_line(0, 0, 0, 8'h40, 8'h02);
    set_bit(A_EN, 0, 0);
    set_bit(A_MASK, 0, 0);
    irq_in[0] = 1;
    wait_msg(10, got);
    chk(!got, "R7 disabled quiet", 32'(got), 0);
    set_bit(A_EN, 0, 1);
    wait_msg(10, got);
    chk(got && msg_line == 0 && msg_vector == 8'h40, "R7 auto-bounce inert",
        32'(msg_vector), 32'h40);
    take();
    retire_line(0);

    // R6 sticky edge latch, write-0 and write-1 clear
    cfg_line(33, 1, 0, 8'h21, 8'h05);
    clear_line(33);
    irq_in[33] = 1; repeat (3) @(negedge clk); irq_in[33] = 0;
    repeat (4) @(negedge clk);
    wr(A_CLR + 4, 32'h0, 4'hF);
    set_bit(A_MASK, 33, 0);
    wait_msg(10, got);
    chk(got && msg_line == 33, "R6 latch kept after clear 0", 32'(msg_line), 33);
    take();
    set_bit(A_MASK, 33, 1);
    clear_line(33);
    irq_in[33] = 1; repeat (3) @(negedge clk); irq_in[33] = 0;
    repeat (4) @(negedge clk);
    clear_line(33);
    set_bit(A_MASK, 33, 0);
    wait_msg(10, got);
    chk(!got, "R6 clear 1 discards latch", 32'(got), 0);
    retire_line(33);

    // R5 level pulse while masked leaves nothing
    cfg_line(20, 0, 0, 8'h14, 8'h03);
    irq_in[20] = 1; repeat (4) @(negedge clk); irq_in[20] = 0;
    repeat (4) @(negedge clk);
    set_bit(A_MASK, 20, 0);
    wait_msg(10, got);
    chk(!got, "R5 level not latched", 32'(got), 0);
    retire_line(20);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule